// File: doc/BRIEF.md
# ISA Plug-and-Play Wake-Up Key Detector

This block is the card-side front end of an ISA Plug-and-Play configuration interface. It watches host I/O write cycles on a reduced ISA bus. The bus carries a 16-bit address, an 8-bit data byte and a write strobe that is high for one clock per write. Two port addresses matter. The index port, 0x279, takes an 8-bit register number. The data port, 0xA79, carries a value for the register that was last named. The block never drives the data bus.

After reset the card sleeps. While it sleeps, bytes written to the index port go to a key matcher, and bytes written to the data port are dropped. The matcher waits for a fixed 32-byte wake-up sequence. Once the last byte of that sequence is seen, the card enters configuration mode. In configuration mode the index port selects a register. The data port can then load an 8-bit card select number, or send the card back to sleep. The matcher resynchronises itself on every wrong byte, so a host that repeats the sequence always gets through, even if an earlier attempt stopped part-way.

Top module: `pnp_key_detect`

## Requirements
- R1: After reset `cfg_active` is 0, `csn` is 0x00 and `sel_index` is 0x00.
- R2: The key has 32 bytes. Byte 0 is 0x6A. Each later byte b' is formed from the byte b before it as b' = {b[0]^b[1], b[7:1]}. When all 32 bytes are written in order to address 0x279 while asleep, `cfg_active` is 1 on the clock after the last write.
- R3: While asleep, a write to 0x279 that does not equal the next expected key byte restarts matching. If that byte is 0x6A, it counts as key byte 0, so the next byte expected is key byte 1.
- R4: A write of 0x00 to 0x279 while asleep makes the matcher expect key byte 0 next, so a complete key that follows a partial one is always accepted.
- R5: A clock cycle with `io_wr` low has no effect, whatever the values on the address and data inputs (for example, a read of 0x279 by parallel-port software).
- R6: While asleep, writes to 0xA79 are dropped: `csn` and `sel_index` do not change.
- R7: In configuration mode, a write to 0x279 sets `sel_index` to the data byte. A write to 0xA79 while `sel_index` is 0x06 loads `csn` with the data byte on the next clock.
- R8: In configuration mode, a write of 0x02 to 0xA79 while `sel_index` is 0x02 sends the block back to sleep on the next clock. It also clears `sel_index` and the match progress, and keeps `csn`. Any other value written to index 0x02 leaves the block awake.
- R9: Only the full 16-bit addresses 0x279 and 0xA79 are decoded. A write to any other address, such as 0x1279 or 0x1A79, has no effect. In configuration mode, a data write to an index other than 0x02 or 0x06 leaves `csn` unchanged.
- R10: A key that stops after 31 correct bytes leaves the block asleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address of the current bus cycle |
| io_data | input | 8 | Write data of the current bus cycle |
| io_wr | input | 1 | I/O write strobe, high for one clock per write |
| cfg_active | output | 1 | 1 in configuration mode, 0 while asleep |
| sel_index | output | 8 | Register index selected through port 0x279 |
| csn | output | 8 | Card select number register |

## Verification
The main test cuts the key short at every one of the 32 positions. It follows each cut with three different endings:
- a corrupted byte and then the rest of the key, which must not wake the card, except when the cut is at position 0;
- a 0x6A restart byte and then the rest of a new key, which must wake the card;
- a pair of zero bytes and then a full key, which must wake the card.

Together these tell a matcher that restarts at the correct index apart from one that stalls, wakes early or ignores the restart rule. Separate runs check the following:
- bus cycles with the write strobe low are dropped in the middle of a key;
- aliased addresses are ignored;
- a key that stops at 31 bytes does not wake the card.

All 256 CSN values are written and read back. Writes to the wrong index and wrong command values are checked as well.

// File: rtl/pnp_key_pkg.sv
package pnp_key_pkg;

    localparam int unsigned BYTE_W = 8;

    // Step from one wake-up key byte to the next one.
    function automatic logic [BYTE_W-1:0] key_step(input logic [BYTE_W-1:0] b);
        return {b[0] ^ b[1], b[BYTE_W-1:1]};
    endfunction

    typedef struct packed {
        logic              idx_wr;
        logic              dat_wr;
        logic [BYTE_W-1:0] wdata;
    } bus_evt_t;

endpackage

// File: rtl/pnp_bus_decode.sv
module pnp_bus_decode
    import pnp_key_pkg::*;
#(
    parameter int unsigned      ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] IDX_PORT = 16'h0279,
    parameter logic [ADDR_W-1:0] DAT_PORT = 16'h0A79
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [BYTE_W-1:0] io_data,
    input  logic              io_wr,
    output bus_evt_t          evt
);

    always_comb begin
        evt.idx_wr = io_wr && (io_addr == IDX_PORT);
        evt.dat_wr = io_wr && (io_addr == DAT_PORT);
        evt.wdata  = io_data;
    end

endmodule

// File: rtl/pnp_key_matcher.sv
module pnp_key_matcher
    import pnp_key_pkg::*;
#(
    parameter int unsigned       KEY_LEN  = 32,
    parameter logic [BYTE_W-1:0] KEY_SEED = 8'h6A
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       idx_wr,
    input  logic [BYTE_W-1:0]          wdata,
    input  logic                       sleep_req,
    output logic                       awake,
    output logic [$clog2(KEY_LEN)-1:0] key_pos
);

    localparam int unsigned        POS_W = $clog2(KEY_LEN);
    localparam logic [POS_W-1:0]   LAST  = POS_W'(KEY_LEN - 1);
    localparam logic [POS_W-1:0]   ONE   = POS_W'(1);
    localparam logic [BYTE_W-1:0]  SEED2 = key_step(KEY_SEED);

    typedef struct packed {
        logic              awake;
        logic [POS_W-1:0]  pos;
        logic [BYTE_W-1:0] expect_b;
    } mstate_t;

    mstate_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (m_q.awake) begin
            if (sleep_req) begin
                m_d.awake    = 1'b0;
                m_d.pos      = '0;
                m_d.expect_b = KEY_SEED;
            end
        end else if (idx_wr) begin
            if (wdata == m_q.expect_b) begin
                if (m_q.pos == LAST) begin
                    m_d.awake    = 1'b1;
                    m_d.pos      = '0;
                    m_d.expect_b = KEY_SEED;
                end else begin
                    m_d.pos      = m_q.pos + ONE;
                    m_d.expect_b = key_step(m_q.expect_b);
                end
            end else if (wdata == KEY_SEED) begin
                m_d.pos      = ONE;
                m_d.expect_b = SEED2;
            end else begin
                m_d.pos      = '0;
                m_d.expect_b = KEY_SEED;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_q.awake    <= 1'b0;
            m_q.pos      <= '0;
            m_q.expect_b <= KEY_SEED;
        end else begin
            m_q <= m_d;
        end
    end

    assign awake   = m_q.awake;
    assign key_pos = m_q.pos;

    AST_WAKE_ONLY_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_q.awake) |-> ($past(m_q.pos) == LAST)); // R2
    AST_SEED_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (!m_q.awake && idx_wr && wdata == KEY_SEED && m_q.pos != '0 && wdata != m_q.expect_b)
        |=> (m_q.pos == ONE)); // R3
    AST_ZERO_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (!m_q.awake && idx_wr && wdata == '0) |=> (m_q.pos == '0 && !m_q.awake)); // R4

endmodule

// File: rtl/pnp_cfg_regs.sv
module pnp_cfg_regs
    import pnp_key_pkg::*;
#(
    parameter logic [BYTE_W-1:0] CSN_IDX  = 8'h06,
    parameter logic [BYTE_W-1:0] CTRL_IDX = 8'h02,
    parameter logic [BYTE_W-1:0] WAIT_CMD = 8'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              awake,
    input  bus_evt_t          evt,
    output logic              sleep_req,
    output logic [BYTE_W-1:0] sel_index,
    output logic [BYTE_W-1:0] csn
);

    typedef struct packed {
        logic [BYTE_W-1:0] sel;
        logic [BYTE_W-1:0] csn;
    } rstate_t;

    rstate_t r_d, r_q;
    logic    go_sleep;

    always_comb begin
        r_d      = r_q;
        go_sleep = awake && evt.dat_wr && (r_q.sel == CTRL_IDX) && (evt.wdata == WAIT_CMD);
        if (awake) begin
            if (evt.idx_wr) begin
                r_d.sel = evt.wdata;
            end
            if (evt.dat_wr && r_q.sel == CSN_IDX) begin
                r_d.csn = evt.wdata;
            end
            if (go_sleep) begin
                r_d.sel = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sleep_req = go_sleep;
    assign sel_index = r_q.sel;
    assign csn       = r_q.csn;

    AST_CSN_FROZEN_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !awake |=> $stable(r_q.csn)); // R6
    AST_SEL_FROZEN_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !awake |=> $stable(r_q.sel)); // R6
    AST_CSN_OTHER_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.dat_wr && r_q.sel != CSN_IDX) |=> $stable(r_q.csn)); // R9

endmodule

// File: rtl/pnp_key_detect.sv
module pnp_key_detect
    import pnp_key_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] IDX_PORT = 16'h0279,
    parameter logic [ADDR_W-1:0] DAT_PORT = 16'h0A79,
    parameter int unsigned       KEY_LEN  = 32,
    parameter logic [7:0]        KEY_SEED = 8'h6A,
    parameter logic [7:0]        CSN_IDX  = 8'h06,
    parameter logic [7:0]        CTRL_IDX = 8'h02,
    parameter logic [7:0]        WAIT_CMD = 8'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_data,
    input  logic              io_wr,
    output logic              cfg_active,
    output logic [7:0]        sel_index,
    output logic [7:0]        csn
);

    localparam int unsigned POS_W = $clog2(KEY_LEN);

    bus_evt_t         evt;
    logic             awake;
    logic             sleep_req;
    logic [POS_W-1:0] key_pos;

    pnp_bus_decode #(
        .ADDR_W   (ADDR_W),
        .IDX_PORT (IDX_PORT),
        .DAT_PORT (DAT_PORT)
    ) u_decode (
        .io_addr (io_addr),
        .io_data (io_data),
        .io_wr   (io_wr),
        .evt     (evt)
    );

    pnp_key_matcher #(
        .KEY_LEN  (KEY_LEN),
        .KEY_SEED (KEY_SEED)
    ) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_wr    (evt.idx_wr),
        .wdata     (evt.wdata),
        .sleep_req (sleep_req),
        .awake     (awake),
        .key_pos   (key_pos)
    );

    pnp_cfg_regs #(
        .CSN_IDX  (CSN_IDX),
        .CTRL_IDX (CTRL_IDX),
        .WAIT_CMD (WAIT_CMD)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .awake     (awake),
        .evt       (evt),
        .sleep_req (sleep_req),
        .sel_index (sel_index),
        .csn       (csn)
    );

    assign cfg_active = awake;

    AST_IDLE_BUS_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        !io_wr |=> ($stable(cfg_active) && $stable(csn) && $stable(sel_index) && $stable(key_pos))); // R5
    AST_WAIT_CMD_SLEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_active && io_wr && io_addr == DAT_PORT && sel_index == CTRL_IDX && io_data == WAIT_CMD)
        |=> (!cfg_active && sel_index == '0 && key_pos == '0)); // R8
    AST_OTHER_ADDR_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr != IDX_PORT && io_addr != DAT_PORT) |=> ($stable(cfg_active) && $stable(csn) && $stable(sel_index))); // R9

endmodule

// File: tb/tb_pnp_key_detect.sv
`timescale 1ns/1ps
module tb_pnp_key_detect;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_data = '0;
    logic        io_wr = 1'b0;
    logic        cfg_active;
    logic [7:0]  sel_index;
    logic [7:0]  csn;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    pnp_key_detect dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_data(io_data),
        .io_wr(io_wr), .cfg_active(cfg_active), .sel_index(sel_index), .csn(csn)
    );

    function automatic logic [7:0] kb(input int i);
        logic [7:0] b = 8'h6A;
        for (int k = 0; k < i; k++) b = {b[0] ^ b[1], b[7:1]};
        return b;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_data = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic send_key(input int from, input int upto);
        for (int i = from; i < upto; i++) wr(16'h0279, kb(i));
    endtask

    task automatic to_sleep();
        wr(16'h0279, 8'h02);
        wr(16'h0A79, 8'h02);
    endtask

    initial begin
        #1000000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cfg", {7'b0, cfg_active}, 8'h00);
        chk("R1 csn", csn, 8'h00);
        chk("R1 sel", sel_index, 8'h00);

        // R6: data port writes while asleep are dropped
        wr(16'h0A79, 8'h55);
        wr(16'h0279, 8'h06);
        wr(16'h0A79, 8'hA7);
        chk("R6 csn asleep", csn, 8'h00);
        chk("R6 sel asleep", sel_index, 8'h00);

        // R9: aliased index port does not count
        wr(16'h0279, 8'h00);
        for (int i = 0; i < 32; i++) wr(16'h1279, kb(i));
        chk("R9 alias key", {7'b0, cfg_active}, 8'h00);

        // R5: strobe-low cycles in the middle of a key are dropped
        wr(16'h0279, 8'h00);
        send_key(0, 16);
        @(negedge clk); io_addr = 16'h0279; io_data = 8'h00; io_wr = 1'b0;
        @(negedge clk); io_data = 8'hFF;
        @(negedge clk);
        send_key(16, 32);
        chk("R5 idle cycles", {7'b0, cfg_active}, 8'h01);
        chk("R6 csn after wake", csn, 8'h00);

        // R7 / R9 register access in configuration mode
        wr(16'h0279, 8'h06);
        chk("R7 sel", sel_index, 8'h06);
        for (int v = 0; v < 256; v++) begin
            wr(16'h0A79, 8'(v));
            chk("R7 csn", csn, 8'(v));
        end
        wr(16'h0A79, 8'h3C);
        wr(16'h1A79, 8'h11);
        chk("R9 alias data", csn, 8'h3C);
        wr(16'h0279, 8'h03);
        wr(16'h0A79, 8'h99);
        chk("R9 other idx", csn, 8'h3C);
        wr(16'h0279, 8'h02);
        wr(16'h0A79, 8'h01);
        chk("R8 wrong cmd", {7'b0, cfg_active}, 8'h01);
        wr(16'h0A79, 8'h02);
        chk("R8 sleep", {7'b0, cfg_active}, 8'h00);
        chk("R8 sel cleared", sel_index, 8'h00);
        chk("R8 csn kept", csn, 8'h3C);

        // R10: 31 bytes only
        send_key(0, 31);
        chk("R10 short key", {7'b0, cfg_active}, 8'h00);

        // Sweep every cut position
        for (int p = 0; p < 32; p++) begin
            // R3: corrupted byte then the rest of the key
            wr(16'h0279, 8'h00); wr(16'h0279, 8'h00);
            send_key(0, p);
            bad = kb(p) ^ 8'h80;
            if (bad == 8'h6A) bad = kb(p) ^ 8'h40;
            wr(16'h0279, bad);
            send_key(p, 32);
            chk("R3 corrupt cut", {7'b0, cfg_active}, (p == 0) ? 8'h01 : 8'h00);
            if (cfg_active) to_sleep();
            // R3: restart with seed byte mid-key
            if (p > 0) begin
                wr(16'h0279, 8'h00);
                send_key(0, p);
                send_key(0, 32);
                chk("R3 seed restart", {7'b0, cfg_active}, 8'h01);
                if (cfg_active) to_sleep();
            end
            // R4 / R2: zero pair after a partial key
            send_key(0, p);
            wr(16'h0279, 8'h00); wr(16'h0279, 8'h00);
            send_key(0, 32);
            chk("R4 resync", {7'b0, cfg_active}, 8'h01);
            chk("R2 sel after wake", sel_index, 8'h00);
            to_sleep();
            chk("R8 back asleep", {7'b0, cfg_active}, 8'h00);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule